// File: doc/BRIEF.md
# Power-Up and Sleep Sequencer for a Parallel Nonvolatile Memory

This block sits between a host and a parallel nonvolatile memory. It decides when the host may access the memory while the supply comes up, while the memory goes into its low-power sleep state, and while it wakes up again. It starts from a "supply good" indication and waits a fixed settling period before it grants access. It drives the memory's active-low sleep pin. Once that pin is low, it stays low for a minimum time. After the pin returns high, the block holds access off for a recovery period.

The host sees a single access-allowed flag. The host asks for sleep with a request line, which the block honours only while access is allowed and no memory cycle is in flight. The host asks to wake with a second request line. A wake request that arrives before the minimum sleep-pin low time has run out is remembered and acted on as soon as that time has run out.

Every delay is given in nanoseconds. Each one is converted to a clock-cycle count from a clock-frequency parameter by rounding up, with a floor of one cycle.

The controller has six states:
- OFF: waits for supply.
- PWR_WAIT: power-up settling.
- READY: access allowed.
- SLEEP_MIN: sleep pin low, minimum time running.
- SLEEP: sleep pin low, waiting for wake.
- WAKE_WAIT: recovery after wake.

Its transitions are:
- OFF to PWR_WAIT when supply is good.
- PWR_WAIT to READY when the power-up timer expires.
- READY to SLEEP_MIN on an accepted sleep request.
- SLEEP_MIN to WAKE_WAIT at expiry if a wake was asked for.
- SLEEP_MIN to SLEEP at expiry otherwise.
- SLEEP to WAKE_WAIT on a wake request.
- WAKE_WAIT to READY when the recovery timer expires.
- Any state to OFF when supply is lost.

Top module: `pwr_sleep_seq`

## Requirements
- R1: While reset is asserted, and while `supply_good` is low, `access_ok` is 0 and `sleep_n` is 1.
- R2: If `supply_good` is sampled high in OFF at clock edge E0, `access_ok` first reads 1 after edge E(PWR_CYC). Here PWR_CYC is the cycle count of PWRUP_NS.
- R3: `access_ok` is 1 only in READY, so it is never 1 while `sleep_n` is 0.
- R4: In READY, a sleep request sampled with `mem_busy` low drives `sleep_n` to 0 and `access_ok` to 0 after that same edge. With `mem_busy` high, the request is not accepted and `access_ok` stays 1.
- R5: Once `sleep_n` goes to 0, it stays 0 for exactly SLEEP_MIN_CYC samples when a wake is asked for early, and for at least that many samples in every case except loss of supply.
- R6: A `wake_req` pulse during SLEEP_MIN is held. The pin returns high right after the minimum time runs out, without a further request. With no wake request, the pin stays low in SLEEP.
- R7: In SLEEP, a `wake_req` drives `sleep_n` to 1 after the sampling edge. `access_ok` then rises exactly WAKE_CYC cycles later.
- R8: If `supply_good` is sampled low in any state, `access_ok` is 0 and `sleep_n` is 1 after that edge. A later return of supply restarts the full power-up wait.
- R9: `sleep_req` has no effect outside READY, and `wake_req` has no effect in OFF, PWR_WAIT, READY and WAKE_WAIT.
- R10: Each delay becomes ceil(ns × CLK_HZ / 10^9) cycles, with a minimum of 1. At CLK_HZ = 10 MHz the defaults give 10000, 10 and 4500 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_good | input | 1 | Supply has reached its minimum operating level |
| mem_busy | input | 1 | A memory read or write cycle is in progress |
| sleep_req | input | 1 | Host asks to put the memory to sleep |
| wake_req | input | 1 | Host asks to wake the memory |
| access_ok | output | 1 | Host may start memory accesses |
| sleep_n | output | 1 | Active-low sleep pin to the memory |

## Verification
The case that needs care is a wake request that lands while the minimum-low timer is still running, because it has to be held until that timer expires. The worst timing is a wake on the very edge where SLEEP_MIN ends, where the held request and the timer expiry meet in one cycle. The bench provokes this with directed pulses at the start of the minimum window and at its last cycle, and with random wake traffic. A second collision is a supply drop in the same cycle as a sleep or wake request, which the random phase produces. In both cases a cycle-level model in the bench predicts `sleep_n` and `access_ok` on every cycle, and the exact pin-low and recovery lengths are measured in cycles.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PWR_WAIT,
        ST_READY,
        ST_SLEEP_MIN,
        ST_SLEEP,
        ST_WAKE_WAIT
    } pss_state_t;

    // Round a delay in nanoseconds up to whole clock cycles, never below one.
    function automatic longint unsigned ns_to_cycles(longint unsigned hz,
                                                     longint unsigned ns);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 64'd0) ? 64'd1 : c;
    endfunction

    function automatic longint unsigned max3(longint unsigned a,
                                             longint unsigned b,
                                             longint unsigned c);
        longint unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pss_timer.sv
module pss_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/pss_wake_hold.sv
module pss_wake_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic wake_req,
    output logic pend
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (!arm) begin
            pend <= 1'b0;
        end else if (wake_req) begin
            pend <= 1'b1;
        end
    end

endmodule

// File: rtl/pwr_sleep_seq.sv
module pwr_sleep_seq #(
    parameter longint unsigned CLK_HZ       = 64'd50_000_000,
    parameter longint unsigned PWRUP_NS     = 64'd1_000_000,
    parameter longint unsigned SLEEP_MIN_NS = 64'd1_000,
    parameter longint unsigned WAKE_NS      = 64'd450_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_good,
    input  logic mem_busy,
    input  logic sleep_req,
    input  logic wake_req,
    output logic access_ok,
    output logic sleep_n
);
    import pss_pkg::*;

    localparam longint unsigned PWR_CYC  = ns_to_cycles(CLK_HZ, PWRUP_NS);
    localparam longint unsigned ZZ_CYC   = ns_to_cycles(CLK_HZ, SLEEP_MIN_NS);
    localparam longint unsigned WAKE_CYC = ns_to_cycles(CLK_HZ, WAKE_NS);
    localparam longint unsigned MAX_CYC  = max3(PWR_CYC, ZZ_CYC, WAKE_CYC);
    localparam int unsigned     CNT_W    = $clog2(MAX_CYC + 64'd1);

    localparam logic [CNT_W-1:0] PWR_LD  = CNT_W'(PWR_CYC - 64'd1);
    localparam logic [CNT_W-1:0] ZZ_LD   = CNT_W'(ZZ_CYC - 64'd1);
    localparam logic [CNT_W-1:0] WAKE_LD = CNT_W'(WAKE_CYC - 64'd1);

    pss_state_t       state, nxt;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             wake_pend;

    pss_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    pss_wake_hold u_wake_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (state == ST_SLEEP_MIN),
        .wake_req (wake_req),
        .pend     (wake_pend)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    // Next state and timer loading
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (!supply_good) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: begin
                    nxt      = ST_PWR_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = PWR_LD;
                end
                ST_PWR_WAIT: begin
                    if (tmr_done) nxt = ST_READY;
                end
                ST_READY: begin
                    if (sleep_req && !mem_busy) begin
                        nxt      = ST_SLEEP_MIN;
                        tmr_load = 1'b1;
                        tmr_val  = ZZ_LD;
                    end
                end
                ST_SLEEP_MIN: begin
                    if (tmr_done) begin
                        if (wake_pend || wake_req) begin
                            nxt      = ST_WAKE_WAIT;
                            tmr_load = 1'b1;
                            tmr_val  = WAKE_LD;
                        end else begin
                            nxt = ST_SLEEP;
                        end
                    end
                end
                ST_SLEEP: begin
                    if (wake_req) begin
                        nxt      = ST_WAKE_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = WAKE_LD;
                    end
                end
                ST_WAKE_WAIT: begin
                    if (tmr_done) nxt = ST_READY;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        access_ok = (state == ST_READY);
        sleep_n   = !((state == ST_SLEEP_MIN) || (state == ST_SLEEP));
    end

endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
    parameter longint unsigned CLK_HZ       = 64'd50_000_000,
    parameter longint unsigned PWRUP_NS     = 64'd1_000_000,
    parameter longint unsigned SLEEP_MIN_NS = 64'd1_000,
    parameter longint unsigned WAKE_NS      = 64'd450_000
) (
    input logic clk,
    input logic rst_n,
    input logic supply_good,
    input logic mem_busy,
    input logic sleep_req,
    input logic wake_req,
    input logic access_ok,
    input logic sleep_n
);
    import pss_pkg::*;

    localparam longint unsigned PWR_CYC  = ns_to_cycles(CLK_HZ, PWRUP_NS);
    localparam longint unsigned ZZ_CYC   = ns_to_cycles(CLK_HZ, SLEEP_MIN_NS);
    localparam longint unsigned WAKE_CYC = ns_to_cycles(CLK_HZ, WAKE_NS);

    longint unsigned low_cnt, high_cnt, sg_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt  <= 64'd0;
            high_cnt <= 64'd0;
            sg_cnt   <= 64'd0;
        end else begin
            low_cnt  <= sleep_n ? 64'd0 : low_cnt + 64'd1;
            high_cnt <= sleep_n ? high_cnt + 64'd1 : 64'd0;
            sg_cnt   <= supply_good ? sg_cnt + 64'd1 : 64'd0;
        end
    end

    assert_acc_awake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        access_ok |-> sleep_n);

    assert_supply_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_good |=> (!access_ok && sleep_n));

    assert_sleep_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_good && access_ok && sleep_req && !mem_busy) |=> !sleep_n);

    assert_busy_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_good && access_ok && sleep_req && mem_busy) |=> access_ok);

    assert_wake_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_good && access_ok && wake_req && !sleep_req) |=> access_ok);

    assert_min_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sleep_n) && $past(supply_good)) |-> (low_cnt >= ZZ_CYC));

    assert_wake_recover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_ok) |-> (high_cnt >= WAKE_CYC));

    assert_pwrup_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_ok) |-> (sg_cnt >= PWR_CYC));

endmodule

bind pwr_sleep_seq pss_checker #(
    .CLK_HZ       (CLK_HZ),
    .PWRUP_NS     (PWRUP_NS),
    .SLEEP_MIN_NS (SLEEP_MIN_NS),
    .WAKE_NS      (WAKE_NS)
) u_pss_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_good (supply_good),
    .mem_busy    (mem_busy),
    .sleep_req   (sleep_req),
    .wake_req    (wake_req),
    .access_ok   (access_ok),
    .sleep_n     (sleep_n)
);

// File: tb/pwr_sleep_seq_bench.sv
module pwr_sleep_seq_bench;

    localparam longint unsigned TB_HZ = 64'd10_000_000;
    // Expected cycle counts worked out by hand from R10 at 10 MHz.
    localparam int PWR  = 10000;
    localparam int ZZ   = 10;
    localparam int WAKE = 4500;

    localparam int M_OFF = 0, M_PWR = 1, M_RDY = 2, M_SMIN = 3, M_SLP = 4, M_WAKE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_good = 1'b0;
    logic mem_busy = 1'b0;
    logic sleep_req = 1'b0;
    logic wake_req = 1'b0;
    logic access_ok, sleep_n;

    always #10 clk = ~clk;

    pwr_sleep_seq #(.CLK_HZ(TB_HZ)) u_pwr_sleep_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_good (supply_good),
        .mem_busy    (mem_busy),
        .sleep_req   (sleep_req),
        .wake_req    (wake_req),
        .access_ok   (access_ok),
        .sleep_n     (sleep_n)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    string cur_tag = "R1";

    int m_st = M_OFF;
    int m_el = 0;
    bit m_pend = 1'b0;

    function automatic bit exp_acc(int s);
        return s == M_RDY;
    endfunction

    function automatic bit exp_sln(int s);
        return !(s == M_SMIN || s == M_SLP);
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_step(bit sg, bit sr, bit wr, bit bz);
        if (!sg) begin
            m_st = M_OFF; m_pend = 1'b0;
        end else begin
            case (m_st)
                M_OFF: begin m_st = M_PWR; m_el = 0; end
                M_PWR: begin m_el++; if (m_el == PWR) m_st = M_RDY; end
                M_RDY: if (sr && !bz) begin m_st = M_SMIN; m_el = 0; m_pend = 1'b0; end
                M_SMIN: begin
                    m_el++;
                    if (wr) m_pend = 1'b1;
                    if (m_el == ZZ) begin
                        m_st = m_pend ? M_WAKE : M_SLP;
                        m_el = 0; m_pend = 1'b0;
                    end
                end
                M_SLP: if (wr) begin m_st = M_WAKE; m_el = 0; end
                M_WAKE: begin m_el++; if (m_el == WAKE) m_st = M_RDY; end
                default: m_st = M_OFF;
            endcase
        end
    endtask

    // One clock: drive at negedge, update model, compare at next negedge.
    task automatic cyc(bit sg, bit sr, bit wr, bit bz);
        supply_good = sg; sleep_req = sr; wake_req = wr; mem_busy = bz;
        model_step(sg, sr, wr, bz);
        @(posedge clk);
        @(negedge clk);
        check(cur_tag, "access_ok", int'(access_ok), int'(exp_acc(m_st)));
        check(cur_tag, "sleep_n", int'(sleep_n), int'(exp_sln(m_st)));
    endtask

    task automatic power_up();
        cyc(1, 0, 0, 0);
        for (int i = 0; i < PWR; i++) cyc(1, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(64'd200_000 * 64'd20);
        n_chk++; n_fail++;
        $display("FAIL watchdog run did not complete actual=1 expected=0");
        finish_run();
    end

    initial begin
        int cnt;
        int unsigned seed;
        seed = $urandom(32'd20240611);

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "access_ok in reset", int'(access_ok), 0);
        check("R1", "sleep_n in reset", int'(sleep_n), 1);
        rst_n = 1'b1;
        cur_tag = "R9";
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0);

        // R2 / R10: power-up length
        cur_tag = "R2";
        cnt = 0;
        cyc(1, 0, 0, 0);
        cnt++;
        while (!access_ok && cnt < PWR + 10) begin cyc(1, 0, 0, 0); cnt++; end
        check("R2", "samples until access_ok", cnt, PWR + 1);
        check("R10", "power-up cycles", cnt - 1, 10000);

        // R9: wake in READY ignored
        cur_tag = "R9";
        for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0);
        check("R9", "access_ok after wake in READY", int'(access_ok), 1);

        // R4: busy blocks, then accepted
        cur_tag = "R4";
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, 1);
        check("R4", "access_ok while busy", int'(access_ok), 1);
        cyc(1, 1, 0, 0);
        check("R4", "sleep_n after accept", int'(sleep_n), 0);
        check("R4", "access_ok after accept", int'(access_ok), 0);

        // R5/R6: early wake pulse held; measure low length
        cur_tag = "R6";
        cnt = 1;
        cyc(1, 0, 1, 0);
        cnt += int'(!sleep_n);
        while (!sleep_n && cnt < ZZ + 10) begin cyc(1, 0, 0, 0); cnt += int'(!sleep_n); end
        check("R5", "sleep_n low samples", cnt, ZZ);
        check("R10", "min low cycles", cnt, 10);

        // R7 / R9: recovery length, sleep_req ignored during it
        cur_tag = "R7";
        cnt = 1;
        while (!access_ok && cnt < WAKE + 10) begin cyc(1, 1, 0, 0); cnt++; end
        check("R7", "recovery samples", cnt, WAKE + 1);

        // R6: no wake keeps pin low; wake on the last SLEEP_MIN edge
        cur_tag = "R6";
        cyc(1, 1, 0, 0);
        for (int i = 0; i < 40; i++) cyc(1, 0, 0, 0);
        check("R6", "sleep_n held in SLEEP", int'(sleep_n), 0);
        cur_tag = "R7";
        cyc(1, 0, 1, 0);
        check("R7", "sleep_n after wake", int'(sleep_n), 1);
        for (int i = 0; i < WAKE; i++) cyc(1, 0, 0, 0);
        check("R7", "access_ok after recovery", int'(access_ok), 1);
        cur_tag = "R6";
        cyc(1, 1, 0, 0);
        for (int i = 0; i < ZZ - 1; i++) cyc(1, 0, 0, 0);
        cyc(1, 0, 1, 0);
        check("R6", "wake on last min edge", int'(sleep_n), 1);

        // R8: supply drop during recovery, then restart mid power-up
        cur_tag = "R8";
        for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0);
        cyc(0, 0, 0, 0);
        check("R8", "sleep_n after drop", int'(sleep_n), 1);
        for (int i = 0; i < 500; i++) cyc(1, 0, 0, 0);
        cyc(0, 0, 0, 0);
        power_up();
        check("R8", "access_ok after full restart", int'(access_ok), 1);
        cyc(1, 1, 0, 0);
        for (int i = 0; i < 30; i++) cyc(1, 0, 0, 0);
        cyc(0, 0, 1, 0);
        check("R8", "access_ok after drop in SLEEP", int'(access_ok), 0);
        check("R8", "sleep_n after drop in SLEEP", int'(sleep_n), 1);

        // Random phase, R3 holds throughout
        cur_tag = "R3";
        for (int i = 0; i < 60000; i++) begin
            bit sg, sr, wr, bz;
            sg = ($urandom_range(0, 19999) != 0);
            sr = ($urandom_range(0, 19) == 0);
            wr = ($urandom_range(0, 29) == 0);
            bz = ($urandom_range(0, 2) == 0);
            cyc(sg, sr, wr, bz);
            if (access_ok && !sleep_n) check("R3", "access while asleep", 1, 0);
        end

        finish_run();
    end

endmodule